// File: doc/BRIEF.md
# Two-Wire Handshaked Link Bridge

The bridge connects a host byte stream, for example a UART with hardware flow control, to a two-wire open-drain link that runs with no clock. The host side has a valid/ready byte port in each direction. Each direction has a small FIFO built from flip-flops. On the link side the block drives each wire through a pull-low enable and reads the wire level back. A wire that nobody pulls reads high.

Each bit is a four-phase handshake with no timeout. The sender pulls one wire low: wire A carries a 0 and wire B carries a 1. The receiver answers by pulling the other wire low. The sender then releases its wire, and the receiver releases its answer after that. The speed of the peer sets the pace of the link. After every acknowledge release, the bridge waits a guard interval before it starts another bit, so that a peer that polls slowly still sees the release. Incoming bits are gathered into bytes and handed to the host. When the receive FIFO has no free slot, the bridge does not start to accept a new byte.

Top module: `link_bridge`

## Requirements
- R1: A bit value 0 is signalled on wire A and a bit value 1 on wire B. The bridge never pulls both wires at once, and it pulls neither wire while idle.
- R2: When transmitting, the bridge keeps its data wire pulled for as long as the peer has not pulled the other wire, however long that is. It releases the data wire once the acknowledge is seen. It starts no further bit while the acknowledge wire is still low.
- R3: Each transmitted byte goes out least significant bit first, as 8 bits. Bytes leave in the order the host accepted them.
- R4: No new transmitted bit begins until at least GUARD_CYCLES clock cycles after the peer's acknowledge wire returned high. The guard is never shorter than 4 cycles.
- R5: Wire inputs pass a two-flop synchroniser and must hold the same level for 2 samples. When one wire reads low and the other reads high, the bridge captures the bit and pulls the opposite wire low. It holds that acknowledge until the sender's wire reads high, then releases it.
- R6: Received bits are assembled least significant bit first into bytes. The bytes appear on the host receive port in arrival order. hostRxValid and hostRxData stay unchanged until hostRxReady accepts the byte.
- R7: hostTxReady goes low once the transmit FIFO holds FIFO_DEPTH bytes. One more byte may already be held in the transmit shifter.
- R8: While the receive FIFO is full, the bridge does not acknowledge the first bit of a new incoming byte. It acknowledges that bit once a slot frees.
- R9: After reset no wire is pulled, hostRxValid is low and hostTxReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock (slow, a few MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| hostTxData | input | 8 | Byte from host toward link |
| hostTxValid | input | 1 | hostTxData is valid |
| hostTxReady | output | 1 | Transmit FIFO can accept a byte |
| hostRxData | output | 8 | Byte received from link |
| hostRxValid | output | 1 | hostRxData is valid |
| hostRxReady | input | 1 | Host takes the byte |
| wireAIn | input | 1 | Sampled level of wire A |
| wireBIn | input | 1 | Sampled level of wire B |
| wireAPull | output | 1 | Pull wire A low when high |
| wireBPull | output | 1 | Pull wire B low when high |

## Verification
Transmit is tested with the bytes 0x00, 0xFF, 0xA5, 0x5A and 0x01. These patterns show whether each bit lands on the correct wire and whether the bit order is reversed or shifted. The peer answers with short, long and very long acknowledge delays. This shows that the bridge waits for the peer and does not rely on timing, and that the guard interval follows each acknowledge release. Receive is tested with a single byte and with a burst that fills the receive FIFO. This shows that bytes keep their order, that acknowledges go on the opposite wire, and that a full FIFO holds off a new byte without losing the stored ones.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam int BITS_PER_BYTE = 8;

  typedef logic [BITS_PER_BYTE-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_PULL,
    ST_TX_REL,
    ST_RX_ACK,
    ST_GUARD
  } linkState_t;

  typedef struct packed {
    logic txLoad;
    logic txAdvance;
    logic rxCapture;
    logic rxBit;
    logic rxLast;
  } ctrlStrobe_t;
endpackage

// File: rtl/lnk_fifo.sv
module lnk_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    fill;
  logic             doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign doPush  = pushEn && !full;
  assign doPop   = popEn && !empty;
  assign popData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/lnk_datapath.sv
module lnk_datapath
  import lnk_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  byte_t       hostTxData,
  input  logic        hostTxValid,
  output logic        hostTxReady,
  output byte_t       hostRxData,
  output logic        hostRxValid,
  input  logic        hostRxReady,
  input  logic        wireAIn,
  input  logic        wireBIn,
  output logic        txAvail,
  output logic        txBitVal,
  output logic        rxFull,
  output logic        lvlA,
  output logic        lvlB
);
  logic [1:0] pinIn, lvl;
  assign pinIn = {wireBIn, wireAIn};

  for (genvar w = 0; w < 2; w++) begin : g_filt
    logic s1, s2, s3, lvlQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        s1   <= 1'b1;
        s2   <= 1'b1;
        s3   <= 1'b1;
        lvlQ <= 1'b1;
      end else begin
        s1 <= pinIn[w];
        s2 <= s1;
        s3 <= s2;
        if (s2 == s3) lvlQ <= s2;
      end
    end
    assign lvl[w] = lvlQ;
  end

  assign lvlA = lvl[0];
  assign lvlB = lvl[1];

  // host -> link
  byte_t txHead, txSr;
  logic  txEmpty, txFull;

  lnk_fifo #(.WIDTH(BITS_PER_BYTE), .DEPTH(FIFO_DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .pushEn(hostTxValid), .pushData(hostTxData),
    .popEn(strobe.txLoad), .popData(txHead),
    .empty(txEmpty), .full(txFull)
  );

  assign hostTxReady = !txFull;
  assign txAvail     = !txEmpty;
  assign txBitVal    = txSr[0];

  always_ff @(posedge clk) begin
    if (!rstN)                 txSr <= '0;
    else if (strobe.txLoad)    txSr <= txHead;
    else if (strobe.txAdvance) txSr <= {1'b0, txSr[BITS_PER_BYTE-1:1]};
  end

  // link -> host
  logic [BITS_PER_BYTE-2:0] rxSr;
  logic                     rxEmpty;

  always_ff @(posedge clk) begin
    if (!rstN)                 rxSr <= '0;
    else if (strobe.rxCapture) rxSr <= {strobe.rxBit, rxSr[BITS_PER_BYTE-2:1]};
  end

  lnk_fifo #(.WIDTH(BITS_PER_BYTE), .DEPTH(FIFO_DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .pushEn(strobe.rxCapture && strobe.rxLast), .pushData({strobe.rxBit, rxSr}),
    .popEn(hostRxReady), .popData(hostRxData),
    .empty(rxEmpty), .full(rxFull)
  );

  assign hostRxValid = !rxEmpty;
endmodule

// File: rtl/lnk_ctrl.sv
module lnk_ctrl
  import lnk_pkg::*;
#(
  parameter int GUARD_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lvlA,
  input  logic        lvlB,
  input  logic        txAvail,
  input  logic        txBitVal,
  input  logic        rxFull,
  output ctrlStrobe_t strobe,
  output logic        pullA,
  output logic        pullB
);
  localparam int GUARD_EFF = (GUARD_CYCLES < 4) ? 4 : GUARD_CYCLES;
  localparam int GW        = $clog2(GUARD_EFF + 1);
  localparam int TW        = $clog2(BITS_PER_BYTE + 1);
  localparam int RW        = $clog2(BITS_PER_BYTE);

  linkState_t    state;
  logic [TW-1:0] txLeft;
  logic [RW-1:0] rxCnt;
  logic [GW-1:0] guardCnt;
  logic          curBit;
  logic          rxStart, busIdle, otherLvl, senderLvl;

  assign busIdle   = lvlA && lvlB;
  assign rxStart   = (lvlA ^ lvlB) && ((rxCnt != '0) || !rxFull);
  assign otherLvl  = curBit ? lvlA : lvlB;
  assign senderLvl = curBit ? lvlB : lvlA;

  always_comb begin
    strobe = '0;
    strobe.rxBit  = lvlA;
    strobe.rxLast = (rxCnt == RW'(BITS_PER_BYTE - 1));
    if (state == ST_IDLE) begin
      if (rxStart)                                    strobe.rxCapture = 1'b1;
      else if (busIdle && txLeft == '0 && txAvail)    strobe.txLoad    = 1'b1;
    end
    if (state == ST_TX_REL && otherLvl) strobe.txAdvance = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      txLeft   <= '0;
      rxCnt    <= '0;
      guardCnt <= '0;
      curBit   <= 1'b0;
      pullA    <= 1'b0;
      pullB    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rxStart) begin
            curBit <= lvlA;
            pullA  <= lvlA;
            pullB  <= !lvlA;
            rxCnt  <= strobe.rxLast ? '0 : rxCnt + RW'(1);
            state  <= ST_RX_ACK;
          end else if (busIdle) begin
            if (txLeft == '0) begin
              if (txAvail) txLeft <= TW'(BITS_PER_BYTE);
            end else begin
              curBit <= txBitVal;
              pullA  <= !txBitVal;
              pullB  <= txBitVal;
              state  <= ST_TX_PULL;
            end
          end
        end
        ST_TX_PULL: if (!otherLvl) begin
          pullA <= 1'b0;
          pullB <= 1'b0;
          state <= ST_TX_REL;
        end
        ST_TX_REL: if (otherLvl) begin
          txLeft   <= txLeft - TW'(1);
          guardCnt <= GW'(GUARD_EFF);
          state    <= ST_GUARD;
        end
        ST_RX_ACK: if (senderLvl) begin
          pullA    <= 1'b0;
          pullB    <= 1'b0;
          guardCnt <= GW'(GUARD_EFF);
          state    <= ST_GUARD;
        end
        ST_GUARD: begin
          if (guardCnt <= GW'(1)) state <= ST_IDLE;
          else                    guardCnt <= guardCnt - GW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_bridge.sv
module link_bridge
  import lnk_pkg::*;
#(
  parameter int FIFO_DEPTH   = 4,
  parameter int GUARD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] hostTxData,
  input  logic       hostTxValid,
  output logic       hostTxReady,
  output logic [7:0] hostRxData,
  output logic       hostRxValid,
  input  logic       hostRxReady,
  input  logic       wireAIn,
  input  logic       wireBIn,
  output logic       wireAPull,
  output logic       wireBPull
);
  ctrlStrobe_t strobe;
  logic txAvail, txBitVal, rxFull, lvlA, lvlB;

  lnk_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostTxData(hostTxData), .hostTxValid(hostTxValid), .hostTxReady(hostTxReady),
    .hostRxData(hostRxData), .hostRxValid(hostRxValid), .hostRxReady(hostRxReady),
    .wireAIn(wireAIn), .wireBIn(wireBIn),
    .txAvail(txAvail), .txBitVal(txBitVal), .rxFull(rxFull),
    .lvlA(lvlA), .lvlB(lvlB)
  );

  lnk_ctrl #(.GUARD_CYCLES(GUARD_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .lvlA(lvlA), .lvlB(lvlB),
    .txAvail(txAvail), .txBitVal(txBitVal), .rxFull(rxFull),
    .strobe(strobe), .pullA(wireAPull), .pullB(wireBPull)
  );
endmodule

// File: rtl/link_bridge_chk.sv
module link_bridge_chk #(
  parameter int GUARD_CYCLES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] hostRxData,
  input logic       hostRxValid,
  input logic       hostRxReady,
  input logic       wireAIn,
  input logic       wireBIn,
  input logic       wireAPull,
  input logic       wireBPull
);
  localparam int GUARD_EFF = (GUARD_CYCLES < 4) ? 4 : GUARD_CYCLES;

  logic [15:0] quietCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                        quietCnt <= '1;
    else if (wireAPull || wireBPull)  quietCnt <= '0;
    else if (quietCnt != '1)          quietCnt <= quietCnt + 16'd1;
  end

  a_r1_single_wire: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wireAPull, wireBPull}));

  // R4: a bit started on an idle bus follows a quiet stretch of at least the guard
  a_r4_guard_gap: assert property (@(posedge clk) disable iff (!rstN)
    (($rose(wireAPull) || $rose(wireBPull)) && $past(wireAIn && wireBIn))
      |-> ($past(quietCnt) >= 16'(GUARD_EFF)));

  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hostRxValid && !hostRxReady) |=> (hostRxValid && $stable(hostRxData)));

  a_r6_rx_drop_only_on_take: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostRxValid) |-> $past(hostRxReady));
endmodule

bind link_bridge link_bridge_chk #(.GUARD_CYCLES(GUARD_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .hostRxData(hostRxData), .hostRxValid(hostRxValid),
  .hostRxReady(hostRxReady), .wireAIn(wireAIn), .wireBIn(wireBIn),
  .wireAPull(wireAPull), .wireBPull(wireBPull)
);

// File: tb/link_bridge_tb_top.sv
module link_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int GUARD      = 16;
  localparam int LIMIT      = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] hostTxData = '0;
  logic hostTxValid = 1'b0;
  logic hostTxReady;
  logic [7:0] hostRxData;
  logic hostRxValid;
  logic hostRxReady = 1'b0;
  logic peerPullA = 1'b0, peerPullB = 1'b0;
  logic wireAPull, wireBPull, wireAIn, wireBIn;

  assign wireAIn = !(wireAPull || peerPullA);
  assign wireBIn = !(wireBPull || peerPullB);

  always #(CLK_PERIOD / 2) clk = !clk;

  link_bridge #(.FIFO_DEPTH(DEPTH), .GUARD_CYCLES(GUARD)) dut_i (
    .clk(clk), .rstN(rstN),
    .hostTxData(hostTxData), .hostTxValid(hostTxValid), .hostTxReady(hostTxReady),
    .hostRxData(hostRxData), .hostRxValid(hostRxValid), .hostRxReady(hostRxReady),
    .wireAIn(wireAIn), .wireBIn(wireBIn), .wireAPull(wireAPull), .wireBPull(wireBPull)
  );

  int checkCnt = 0, failCnt = 0, cyc = 0, lastRel = 0;
  bit haveRel = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  task automatic hostPush(input logic [7:0] b);
    int t = 0;
    @(negedge clk);
    hostTxData  = b;
    hostTxValid = 1'b1;
    while (!hostTxReady && t < LIMIT) begin @(negedge clk); t++; end
    @(negedge clk);
    hostTxValid = 1'b0;
  endtask

  task automatic hostPop(output logic [7:0] b);
    int t = 0;
    @(negedge clk);
    while (!hostRxValid && t < LIMIT) begin @(negedge clk); t++; end
    check(hostRxValid, "R6 rx byte presented", hostRxValid, 1);
    b = hostRxData;
    hostRxReady = 1'b1;
    @(negedge clk);
    hostRxReady = 1'b0;
  endtask

  // peer takes one byte from the bridge, answering each bit after ackDelay cycles
  task automatic peerRecvByte(input int ackDelay, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      int t;
      bit isB;
      t = 0;
      while (!(wireAPull || wireBPull) && t < LIMIT) begin @(negedge clk); t++; end
      check(wireAPull || wireBPull, "R2 bit started", {wireAPull, wireBPull}, 1);
      check(!(wireAPull && wireBPull), "R1 one wire per bit", {wireAPull, wireBPull}, 1);
      if (haveRel) check(cyc - lastRel >= GUARD, "R4 guard gap", cyc - lastRel, GUARD);
      isB = wireBPull;
      got[i] = isB;
      repeat (ackDelay) @(negedge clk);
      check(isB ? wireBPull : wireAPull, "R2 data held until ack", 0, 1);
      if (isB) peerPullA = 1'b1; else peerPullB = 1'b1;
      t = 0;
      while ((isB ? wireBPull : wireAPull) && t < LIMIT) begin @(negedge clk); t++; end
      check(!(isB ? wireBPull : wireAPull), "R2 data released after ack", 1, 0);
      repeat (ackDelay + 2) @(negedge clk);
      check(!wireAPull && !wireBPull, "R2 no bit while ack low", {wireAPull, wireBPull}, 0);
      peerPullA = 1'b0;
      peerPullB = 1'b0;
      lastRel = cyc;
      haveRel = 1;
    end
  endtask

  // peer sends one byte to the bridge, holding each bit holdDelay cycles after the ack
  task automatic peerSendByte(input logic [7:0] b, input int holdDelay);
    for (int i = 0; i < 8; i++) begin
      int t;
      bit v;
      v = b[i];
      repeat (20) @(negedge clk);
      if (v) peerPullB = 1'b1; else peerPullA = 1'b1;
      t = 0;
      while (!(v ? wireAPull : wireBPull) && t < LIMIT) begin @(negedge clk); t++; end
      check(v ? wireAPull : wireBPull, "R5 ack on opposite wire", 0, 1);
      check(!(v ? wireBPull : wireAPull), "R1 ack not on data wire", 1, 0);
      repeat (holdDelay) @(negedge clk);
      check(v ? wireAPull : wireBPull, "R5 ack held while sender low", 0, 1);
      peerPullA = 1'b0;
      peerPullB = 1'b0;
      t = 0;
      while ((wireAPull || wireBPull) && t < LIMIT) begin @(negedge clk); t++; end
      check(!wireAPull && !wireBPull, "R5 ack released", {wireAPull, wireBPull}, 0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!wireAPull && !wireBPull, "R9 no pull after reset", {wireAPull, wireBPull}, 0);
    check(!hostRxValid, "R9 rx valid low", hostRxValid, 0);
    check(hostTxReady, "R9 tx ready high", hostTxReady, 1);
  endtask

  task automatic testTxSingle();
    logic [7:0] got;
    hostPush(8'hA5);
    peerRecvByte(3, got);
    check(got == 8'hA5, "R3 single byte lsb first", got, 8'hA5);
  endtask

  task automatic testTxQueue();
    logic [7:0] got;
    hostPush(8'h00);
    hostPush(8'hFF);
    hostPush(8'h5A);
    peerRecvByte(1, got);
    check(got == 8'h00, "R3 queued byte 0", got, 8'h00);
    peerRecvByte(40, got);
    check(got == 8'hFF, "R3 queued byte 1", got, 8'hFF);
    peerRecvByte(7, got);
    check(got == 8'h5A, "R3 queued byte 2", got, 8'h5A);
  endtask

  task automatic testTxHold();
    logic [7:0] got;
    int t = 0;
    hostPush(8'h01);
    while (!(wireAPull || wireBPull) && t < LIMIT) begin @(negedge clk); t++; end
    repeat (500) @(negedge clk);
    check(wireBPull && !wireAPull, "R2 bit held without ack", {wireAPull, wireBPull}, 1);
    peerRecvByte(2, got);
    check(got == 8'h01, "R3 slow peer byte", got, 8'h01);
  endtask

  task automatic testTxFull();
    logic [7:0] got;
    hostPush(8'h10);
    repeat (10) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) hostPush(8'h20 + 8'(i));
    check(!hostTxReady, "R7 ready low when full", hostTxReady, 0);
    peerRecvByte(2, got);
    check(got == 8'h10, "R7 first byte kept", got, 8'h10);
    for (int i = 0; i < DEPTH; i++) begin
      peerRecvByte(2, got);
      check(got == 8'h20 + 8'(i), "R7 fifo byte order", got, 8'h20 + 8'(i));
    end
  endtask

  task automatic testRxSingle();
    logic [7:0] got;
    peerSendByte(8'h3C, 5);
    hostPop(got);
    check(got == 8'h3C, "R6 rx byte lsb first", got, 8'h3C);
  endtask

  task automatic testRxFull();
    logic [7:0] got;
    for (int i = 0; i < DEPTH; i++) peerSendByte(8'h11 * 8'(i + 1), 2);
    peerPullA = 1'b1;
    repeat (300) @(negedge clk);
    check(!wireAPull && !wireBPull, "R8 no ack while full", {wireAPull, wireBPull}, 0);
    check(hostRxValid && hostRxData == 8'h11, "R6 head held while waiting", hostRxData, 8'h11);
    peerPullA = 1'b0;
    repeat (20) @(negedge clk);
    hostPop(got);
    check(got == 8'h11, "R6 rx order 0", got, 8'h11);
    peerSendByte(8'h50, 1);
    for (int i = 1; i < DEPTH; i++) begin
      hostPop(got);
      check(got == 8'h11 * 8'(i + 1), "R6 rx order", got, 8'h11 * 8'(i + 1));
    end
    hostPop(got);
    check(got == 8'h50, "R8 byte accepted after slot freed", got, 8'h50);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog (all R): actual hung, expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTxSingle();
    testTxQueue();
    testTxHold();
    testTxFull();
    testRxSingle();
    testRxFull();
    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule